// File: doc/BRIEF.md
# Shared Line Memory with Latency and Two-Port Arbitration

This block is a synthesizable storage model that makes every access cost a configurable number of cycles. Two requesters share it: a data port and an instruction-fetch port. Storage is organised as lines of four words. A read returns the whole line that holds the addressed word. A write stores exactly one word. Each port presents a request with a read/write select, an address and write data. The port answers with a one-bit response: WAIT (low) or OK (high).

Only one port owns the storage at a time. The owner must keep its request raised until the countdown ends. The countdown advances only while the owner holds its request. The line or the write takes effect only in the completion cycle. A separate debug port reads and writes storage at once and bypasses both the latency and the arbitration.

Top module: `linemem_arb`

## Requirements
- R1: A read returns all four words of the addressed line on `*_rdata`, word k at bits [32k+31:32k]. The two low address bits are ignored for reads.
- R2: With latency LAT, a request held from an idle memory answers WAIT (`*_ok`=0) for LAT consecutive cycles and OK (`*_ok`=1) on cycle LAT+1.
- R3: With LAT=0, a read or write from an idle memory answers OK in the same cycle it is presented.
- R4: A write stores only the word at the exact word address. The line index is address bits [2+:log2(LINES)] and the word index is bits [1:0]. The store happens at the OK cycle, with the same latency as a read.
- R5: While one port owns the memory, the other port answers WAIT, and those blocked cycles do not count toward its own latency.
- R6: In the cycle the owner completes, a request from the other port answers WAIT. Its own full countdown starts in the following cycle.
- R7: After reset, every stored word reads zero, both responses are WAIT and both read-data outputs are zero.
- R8: The debug port shows the addressed line combinationally on `g_line`. A debug write stores one word at the next clock edge, with no latency and no arbitration.
- R9: When both ports raise requests at an idle memory, the data port wins.
- R10: If the owner drops its request before completion, its countdown is cleared and ownership is released. A later request restarts a full countdown.
- R11: Read data equals the line in the cycle of an OK read. In every other cycle the output holds the value from the port's last OK read.
- R12: Addresses beyond the storage depth wrap modulo LINES lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_req | input | 1 | Data port request |
| d_we | input | 1 | Data port write select (1 = write) |
| d_addr | input | AW | Data port word address |
| d_wdata | input | DW | Data port write word |
| d_ok | output | 1 | Data port response, 1 = OK, 0 = WAIT |
| d_rdata | output | 4*DW | Data port read line |
| f_req | input | 1 | Fetch port request |
| f_we | input | 1 | Fetch port write select |
| f_addr | input | AW | Fetch port word address |
| f_wdata | input | DW | Fetch port write word |
| f_ok | output | 1 | Fetch port response |
| f_rdata | output | 4*DW | Fetch port read line |
| g_we | input | 1 | Debug write strobe |
| g_addr | input | AW | Debug word address |
| g_wdata | input | DW | Debug write word |
| g_line | output | 4*DW | Debug read line, no delay |

## Verification
Some properties are checked on every cycle:
- the two responses are never OK together;
- no OK arrives before its port has held the request for at least LAT waiting cycles;
- with nonzero latency, no port completes in the cycle right after the other port completes;
- the read data stays still outside OK reads.

Other properties need the bench scenarios, which replay a shadow model:
- that the exact countdown length is LAT+1;
- that a dropped request restarts from zero;
- that the data port wins a tie;
- that lines wrap and debug accesses are visible;
- that only the addressed word changes on a write.

// File: rtl/linemem_arb.sv
module linemem_arb #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int LAT   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_req,
  input  logic            d_we,
  input  logic [AW-1:0]   d_addr,
  input  logic [DW-1:0]   d_wdata,
  output logic            d_ok,
  output logic [4*DW-1:0] d_rdata,
  input  logic            f_req,
  input  logic            f_we,
  input  logic [AW-1:0]   f_addr,
  input  logic [DW-1:0]   f_wdata,
  output logic            f_ok,
  output logic [4*DW-1:0] f_rdata,
  input  logic            g_we,
  input  logic [AW-1:0]   g_addr,
  input  logic [DW-1:0]   g_wdata,
  output logic [4*DW-1:0] g_line
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int CW = (LAT > 0) ? $clog2(LAT + 1) : 1;

  logic [DW-1:0]   mem [LINES][4];
  logic [1:0]      own;
  logic [CW-1:0]   cnt, cur;
  logic [4*DW-1:0] d_hold, f_hold, d_line, f_line;
  logic            held_d, held_f, busy, gd, gf, done;

  wire [LW-1:0] dl = d_addr[2 +: LW];
  wire [LW-1:0] fl = f_addr[2 +: LW];
  wire [LW-1:0] gl = g_addr[2 +: LW];

  assign held_d = own[0] & d_req;
  assign held_f = own[1] & f_req;
  assign busy   = held_d | held_f;
  assign gd     = held_d | (~busy & d_req);
  assign gf     = held_f | (~busy & ~d_req & f_req);
  assign cur    = busy ? cnt : '0;
  assign done   = (gd | gf) && (cur == CW'(LAT));
  assign d_ok   = gd & done;
  assign f_ok   = gf & done;

  assign d_line = {mem[dl][3], mem[dl][2], mem[dl][1], mem[dl][0]};
  assign f_line = {mem[fl][3], mem[fl][2], mem[fl][1], mem[fl][0]};
  assign g_line = {mem[gl][3], mem[gl][2], mem[gl][1], mem[gl][0]};

  assign d_rdata = (d_ok & ~d_we) ? d_line : d_hold;
  assign f_rdata = (f_ok & ~f_we) ? f_line : f_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= '0;
      cnt <= '0;
    end else if (done || !(gd | gf)) begin
      own <= '0;
      cnt <= '0;
    end else begin
      own <= {gf, gd};
      cnt <= cur + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_hold <= '0;
      f_hold <= '0;
    end else begin
      if (d_ok && !d_we) d_hold <= d_line;
      if (f_ok && !f_we) f_hold <= f_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < 4; w++)
          mem[l][w] <= '0;
    end else begin
      if (d_ok && d_we) mem[dl][d_addr[1:0]] <= d_wdata;
      if (f_ok && f_we) mem[fl][f_addr[1:0]] <= f_wdata;
      if (g_we)         mem[gl][g_addr[1:0]] <= g_wdata;
    end
  end
endmodule

module linemem_arb_chk #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            d_req,
  input logic            d_we,
  input logic            d_ok,
  input logic [4*DW-1:0] d_rdata,
  input logic            f_req,
  input logic            f_we,
  input logic            f_ok,
  input logic [4*DW-1:0] f_rdata
);
  logic [15:0] dwait, fwait;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwait <= '0;
      fwait <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      dwait <= (!d_req || d_ok) ? '0 : (dwait == 16'hFFFF ? dwait : dwait + 16'd1);
      fwait <= (!f_req || f_ok) ? '0 : (fwait == 16'hFFFF ? fwait : fwait + 16'd1);
    end
  end

  assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_ok && f_ok));
  assert_ok_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_ok |-> d_req) and (f_ok |-> f_req));
  assert_d_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    d_ok |-> (32'(dwait) >= LAT));
  assert_f_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    f_ok |-> (32'(fwait) >= LAT));
  assert_handoff_d_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((LAT > 0) && d_ok) |=> !f_ok);
  assert_handoff_f_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((LAT > 0) && f_ok) |=> !d_ok);
  assert_d_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(d_ok && !d_we)) |-> $stable(d_rdata));
  assert_f_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(f_ok && !f_we)) |-> $stable(f_rdata));
endmodule

bind linemem_arb linemem_arb_chk #(.DW(DW), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .d_req(d_req), .d_we(d_we), .d_ok(d_ok), .d_rdata(d_rdata),
  .f_req(f_req), .f_we(f_we), .f_ok(f_ok), .f_rdata(f_rdata)
);

// File: tb/linemem_arb_test.sv
module linemem_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 32, LINES = 16;
  localparam logic [31:0] DBASE = 32'h11223311, FBASE = 32'hA0000000;

  function automatic logic [25:0] v(input logic dr, dw, input logic [7:0] da,
                                    input logic fr, fw, input logic [7:0] fa,
                                    input logic [3:0] rep, input logic ed, ef);
    return {dr, dw, da, fr, fw, fa, rep, ed, ef};
  endfunction

  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    v(1,1,8'h00, 0,0,8'h00, 4, 1,0),  // R4 R2 write word 0
    v(1,1,8'h01, 0,0,8'h00, 4, 1,0),  // R4
    v(1,1,8'h02, 0,0,8'h00, 4, 1,0),  // R4
    v(1,1,8'h03, 0,0,8'h00, 4, 1,0),  // R4
    v(1,0,8'h02, 1,0,8'h03, 4, 1,0),  // R5 R1 fetch blocked
    v(0,0,8'h00, 1,0,8'h03, 4, 0,1),  // R6 fetch starts after handoff
    v(1,0,8'h10, 1,0,8'h20, 4, 1,0),  // R9 tie goes to data
    v(0,0,8'h00, 1,0,8'h20, 4, 0,1),  // R9
    v(0,0,8'h00, 1,1,8'h25, 2, 0,0),  // R10 partial countdown
    v(0,0,8'h00, 0,0,8'h00, 1, 0,0),  // R10 drop
    v(0,0,8'h00, 1,1,8'h25, 4, 0,1),  // R10 full restart
    v(0,0,8'h00, 1,0,8'h24, 2, 0,0),  // R5
    v(1,0,8'h01, 1,0,8'h24, 2, 0,1),  // R5 data blocked meanwhile
    v(1,0,8'h01, 0,0,8'h00, 4, 1,0),  // R6
    v(1,1,8'h41, 0,0,8'h00, 4, 1,0),  // R12 wraps onto line 0
    v(1,0,8'h03, 0,0,8'h00, 4, 1,0)   // R1 R12
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic d_req = 0, d_we = 0, f_req = 0, f_we = 0, g_we = 0;
  logic [AW-1:0] d_addr = '0, f_addr = '0, g_addr = '0;
  logic [DW-1:0] d_wdata = '0, f_wdata = '0, g_wdata = '0;
  logic d_ok, f_ok;
  logic [4*DW-1:0] d_rdata, f_rdata, g_line;

  logic z_dreq = 0, z_dwe = 0, z_freq = 0;
  logic [AW-1:0] z_daddr = '0, z_faddr = '0;
  logic [DW-1:0] z_dwdata = '0;
  logic z_dok, z_fok;
  logic [4*DW-1:0] z_drdata, z_frdata, z_gline;

  logic [31:0] mdl [64];
  logic [4*DW-1:0] dh, fh;
  int checks = 0, fails = 0;
  logic wd_fired = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linemem_arb #(.AW(AW), .DW(DW), .LINES(LINES), .LAT(3)) uut (
    .clk(clk), .rst_n(rst_n),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_ok(d_ok), .d_rdata(d_rdata),
    .f_req(f_req), .f_we(f_we), .f_addr(f_addr), .f_wdata(f_wdata), .f_ok(f_ok), .f_rdata(f_rdata),
    .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata), .g_line(g_line));

  linemem_arb #(.AW(AW), .DW(DW), .LINES(LINES), .LAT(0)) uut0 (
    .clk(clk), .rst_n(rst_n),
    .d_req(z_dreq), .d_we(z_dwe), .d_addr(z_daddr), .d_wdata(z_dwdata), .d_ok(z_dok), .d_rdata(z_drdata),
    .f_req(z_freq), .f_we(1'b0), .f_addr(z_faddr), .f_wdata('0), .f_ok(z_fok), .f_rdata(z_frdata),
    .g_we(1'b0), .g_addr('0), .g_wdata('0), .g_line(z_gline));

  task automatic chk(input string tag, input logic [4*DW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4*DW-1:0] mline(input logic [7:0] a);
    int b = int'(a[5:2]) * 4;
    return {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    wd_fired = 1;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    dh = '0; fh = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset state
    chk("R7 d_ok", {127'd0, d_ok}, '0);
    chk("R7 f_ok", {127'd0, f_ok}, '0);
    chk("R7 d_rdata", d_rdata, '0);
    for (int l = 0; l < LINES; l++) begin
      g_addr = 8'(l * 4);
      #1;
      chk("R7 line zero", g_line, '0);
    end
    @(negedge clk);

    for (int e = 0; e < NV; e++) begin
      logic [25:0] x;
      x = VEC[e];
      for (int k = 0; k < int'(x[5:2]); k++) begin
        logic ed, ef;
        d_req = x[25]; d_we = x[24]; d_addr = x[23:16]; d_wdata = DBASE + 32'(x[23:16]);
        f_req = x[15]; f_we = x[14]; f_addr = x[13:6];  f_wdata = FBASE + 32'(x[13:6]);
        ed = x[1] && (k == int'(x[5:2]) - 1);
        ef = x[0] && (k == int'(x[5:2]) - 1);
        #1;
        chk("R2 R5 R6 R9 R10 d_ok", {127'd0, d_ok}, {127'd0, ed});
        chk("R2 R5 R6 R9 R10 f_ok", {127'd0, f_ok}, {127'd0, ef});
        if (ed && !d_we) begin
          dh = mline(d_addr);
          chk("R1 R11 d line", d_rdata, dh);
        end else chk("R11 d hold", d_rdata, dh);
        if (ef && !f_we) begin
          fh = mline(f_addr);
          chk("R1 R11 f line", f_rdata, fh);
        end else chk("R11 f hold", f_rdata, fh);
        if (ed && d_we) mdl[d_addr[5:0]] = d_wdata;
        if (ef && f_we) mdl[f_addr[5:0]] = f_wdata;
        @(negedge clk);
      end
    end
    d_req = 0; f_req = 0;

    // R4 only addressed word changed; R12 wrap visible on line 0
    g_addr = 8'h00; #1;
    chk("R4 R12 line0", g_line,
        {DBASE + 32'h3, DBASE + 32'h2, DBASE + 32'h41, DBASE});
    g_addr = 8'h24; #1;
    chk("R4 line9", g_line, {32'd0, 32'd0, FBASE + 32'h25, 32'd0});

    // R8 debug write, visible right after the edge
    g_addr = 8'h3A; g_wdata = 32'hCAFE0001; g_we = 1;
    @(negedge clk);
    g_we = 0; #1;
    chk("R8 debug write", g_line, {32'd0, 32'hCAFE0001, 64'd0});
    d_req = 1; d_we = 0; d_addr = 8'h38;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R8 R2 port sees debug", {127'd0, d_ok}, {127'd0, k == 3});
      @(negedge clk);
    end
    d_req = 0;
    chk("R11 hold after read", d_rdata, {32'd0, 32'hCAFE0001, 64'd0});

    // R3 zero latency
    z_dreq = 1; z_dwe = 1; z_daddr = 8'h05; z_dwdata = 32'h5A5A0005; #1;
    chk("R3 write same cycle", {127'd0, z_dok}, 128'd1);
    @(negedge clk);
    z_dwe = 0; z_daddr = 8'h04; #1;
    chk("R3 read same cycle", {127'd0, z_dok}, 128'd1);
    chk("R3 R1 read line", z_drdata, {64'd0, 32'h5A5A0005, 32'd0});
    @(negedge clk);
    z_freq = 1; z_faddr = 8'h06; #1;
    chk("R9 R3 tie data", {126'd0, z_dok, z_fok}, 128'b10);
    @(negedge clk);
    z_dreq = 0; #1;
    chk("R6 R3 fetch next", {126'd0, z_dok, z_fok}, 128'b01);
    chk("R3 fetch line", z_frdata, {64'd0, 32'h5A5A0005, 32'd0});
    @(negedge clk);
    z_freq = 0;

    if (!wd_fired) begin
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule